// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a processor whose 20-bit address shares pins with other information. The low 16 address lines also carry data, and the top 4 lines also carry status. A requester presents a cycle kind, a 20-bit address, a 2-bit segment code, an active-low high-byte enable and write data. It holds them steady until the block takes the request. The sequencer then walks through the phases T1, T2, T3, optional wait phases, and T4. In each phase it puts the right information on the shared lines and drives the strobes.

The cycle kind is the 3-bit status code that appears on the status pins: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write. Code 111 is the passive code and is never a cycle. Read data comes back on a separate response port and is marked by a one-cycle done pulse. A new request may be taken in the idle state or during T4, so cycles can follow each other without a gap.

Top module: `mbus_seq`

## Requirements
- R1: While reset is held, and in the idle state, the outputs are at rest: status 111, address strobe low, read, data-enable, acknowledge and high-byte-enable strobes all high, and the shared lines not driven.
- R2: A request that is taken (req_take high at a clock edge) is followed by T1, T2, T3 and T4 on the next four cycles when ready is high. rsp_done is high for exactly the T4 cycle.
- R3: bus_ale is high only in T1. In T1 the low lines carry address bits 15:0 with bus_ad_oe high, the upper lines carry address bits 19:16, and bus_bhe_n carries the requested value. Outside T1, bus_bhe_n is high.
- R4: bus_stat shows the cycle kind in the cycle where the request is taken, in T1 and in T2. It shows 111 in T3, in wait phases, and in a T4 that is not followed by a new request.
- R5: From T2 through T4, bus_a_hi carries the segment code in bits 1:0 and zeros in bits 3:2. The codes are 00 extra, 01 stack, 10 code and 11 data.
- R6: A low bus_ready sampled at the end of T3 or of a wait phase adds one more wait phase. Each wait phase holds the same strobe levels as T3.
- R7: bus_rd_n is low in T2, T3 and the wait phases of kinds 000, 001, 100 and 101. It is high at all other times.
- R8: bus_inta_n is low in T2, T3 and the wait phases of kind 000 only.
- R9: bus_den_n is low from T2 through the last T3 or wait phase of read and acknowledge kinds, and from T2 through T4 of write kinds (010, 110). It stays high throughout a halt cycle (011).
- R10: In write cycles, bus_ad_out carries the write data with bus_ad_oe high from T2 through T4. In all other cycles, bus_ad_oe is low after T1.
- R11: bus_ad_in is captured at the clock edge that ends the T3 or wait phase in which bus_ready is high. The captured value appears on rsp_rdata in T4 and is held until the next capture.
- R12: A request with kind 111 is never taken: req_take stays low and no cycle starts.
- R13: A request presented during T4 is taken in that T4, bus_stat shows its kind in that T4, and its T1 follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind, equal to its status code |
| req_addr | input | 20 | Physical address |
| req_seg | input | 2 | Segment code in use |
| req_bhe_n | input | 1 | Active-low high-byte enable for the cycle |
| req_wdata | input | 16 | Write data |
| req_take | output | 1 | Request taken at this clock edge |
| bus_ready | input | 1 | Ready from memory or device |
| bus_ad_in | input | 16 | Data read from the shared low lines |
| bus_ad_out | output | 16 | Value driven on the shared low lines |
| bus_ad_oe | output | 1 | Output enable for the shared low lines |
| bus_a_hi | output | 4 | Upper address lines, or segment code after T1 |
| bus_stat | output | 3 | Cycle status code |
| bus_ale | output | 1 | Address latch strobe |
| bus_bhe_n | output | 1 | Active-low high-byte enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_den_n | output | 1 | Active-low data enable |
| bus_inta_n | output | 1 | Active-low interrupt acknowledge strobe |
| rsp_done | output | 1 | Cycle finishing (T4) |
| rsp_rdata | output | 16 | Captured read data |

## Verification
The assertions assume that bus_ready is a clean, known level at every clock edge. They also assume that a requester keeps kind, address, segment and data stable from the cycle it raises req_valid until req_take. The stimulus changes inputs only on the falling clock edge, away from the sampling edge. It holds every request field constant until the block takes it, and drops req_valid in the T1 that follows. The ready input is driven high only when a wait sequence is meant to end. The read lines carry a decoy value in every phase except the capturing one, so a capture at the wrong edge shows up.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  localparam logic [2:0] KIND_INTA = 3'b000;
  localparam logic [2:0] KIND_IORD = 3'b001;
  localparam logic [2:0] KIND_IOWR = 3'b010;
  localparam logic [2:0] KIND_HALT = 3'b011;
  localparam logic [2:0] KIND_CODE = 3'b100;
  localparam logic [2:0] KIND_MRD  = 3'b101;
  localparam logic [2:0] KIND_MWR  = 3'b110;
  localparam logic [2:0] KIND_PASV = 3'b111;

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == KIND_INTA) || (k == KIND_IORD) || (k == KIND_CODE) || (k == KIND_MRD);
  endfunction

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == KIND_IOWR) || (k == KIND_MWR);
  endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic       ready,
  output phase_t     phase,
  output logic       take,
  output logic       rd_capture
);

  phase_t phase_q, phase_d;

  // a request can enter only from idle or the closing phase
  assign take = req_valid && (req_kind != KIND_PASV) &&
                ((phase_q == PH_IDLE) || (phase_q == PH_T4));

  assign rd_capture = ready && ((phase_q == PH_T3) || (phase_q == PH_TW));

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (take) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = ready ? PH_T4 : PH_TW;
      PH_TW:   phase_d = ready ? PH_T4 : PH_TW;
      PH_T4:   phase_d = take ? PH_T1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/mbus_reqlat.sv
module mbus_reqlat
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              rd_capture,
  input  logic [2:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic              in_bhe_n,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] in_rdata,
  output logic [2:0]        kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SEG_W-1:0]  seg_q,
  output logic              bhe_n_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_PASV;
      addr_q  <= '0;
      seg_q   <= '0;
      bhe_n_q <= 1'b1;
      wdata_q <= '0;
    end else if (load_en) begin
      kind_q  <= in_kind;
      addr_q  <= in_addr;
      seg_q   <= in_seg;
      bhe_n_q <= in_bhe_n;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (rd_capture) rdata_q <= in_rdata;
  end

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  phase_t            phase,
  input  logic              take,
  input  logic [2:0]        new_kind,
  input  logic [2:0]        kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [SEG_W-1:0]  seg_q,
  input  logic              bhe_n_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [2:0]        stat,
  output logic              ale,
  output logic              bhe_n,
  output logic              rd_n,
  output logic              den_n,
  output logic              inta_n
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic in_t1, after_t1, strobe_ph, is_rd, is_wr;
  logic [HI_W-1:0] seg_ext;

  assign in_t1     = (phase == PH_T1);
  assign after_t1  = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
  assign strobe_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
  assign is_rd     = kind_reads(kind_q);
  assign is_wr     = kind_writes(kind_q);
  assign seg_ext   = HI_W'(seg_q);

  always_comb begin
    if (in_t1 || (phase == PH_T2)) stat = kind_q;
    else if (take)                 stat = new_kind;
    else                           stat = KIND_PASV;
  end

  assign ale    = in_t1;
  assign ad_out = in_t1 ? addr_q[DATA_W-1:0] : wdata_q;
  assign ad_oe  = in_t1 || (after_t1 && is_wr);
  assign a_hi   = in_t1 ? addr_q[ADDR_W-1:DATA_W] : (after_t1 ? seg_ext : '0);
  assign bhe_n  = in_t1 ? bhe_n_q : 1'b1;
  assign rd_n   = !(strobe_ph && is_rd);
  assign inta_n = !(strobe_ph && (kind_q == KIND_INTA));
  assign den_n  = !((strobe_ph && (kind_q != KIND_HALT)) || ((phase == PH_T4) && is_wr));

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              req_bhe_n,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_take,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  output logic [HI_W-1:0]   bus_a_hi,
  output logic [2:0]        bus_stat,
  output logic              bus_ale,
  output logic              bus_bhe_n,
  output logic              bus_rd_n,
  output logic              bus_den_n,
  output logic              bus_inta_n,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  phase_t            phase;
  logic              take, rd_capture;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SEG_W-1:0]  seg_q;
  logic              bhe_n_q;
  logic [DATA_W-1:0] wdata_q;

  mbus_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .ready      (bus_ready),
    .phase      (phase),
    .take       (take),
    .rd_capture (rd_capture)
  );

  mbus_reqlat #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (take),
    .rd_capture (rd_capture),
    .in_kind    (req_kind),
    .in_addr    (req_addr),
    .in_seg     (req_seg),
    .in_bhe_n   (req_bhe_n),
    .in_wdata   (req_wdata),
    .in_rdata   (bus_ad_in),
    .kind_q     (kind_q),
    .addr_q     (addr_q),
    .seg_q      (seg_q),
    .bhe_n_q    (bhe_n_q),
    .wdata_q    (wdata_q),
    .rdata_q    (rsp_rdata)
  );

  mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_drv (
    .phase    (phase),
    .take     (take),
    .new_kind (req_kind),
    .kind_q   (kind_q),
    .addr_q   (addr_q),
    .seg_q    (seg_q),
    .bhe_n_q  (bhe_n_q),
    .wdata_q  (wdata_q),
    .ad_out   (bus_ad_out),
    .ad_oe    (bus_ad_oe),
    .a_hi     (bus_a_hi),
    .stat     (bus_stat),
    .ale      (bus_ale),
    .bhe_n    (bus_bhe_n),
    .rd_n     (bus_rd_n),
    .den_n    (bus_den_n),
    .inta_n   (bus_inta_n)
  );

  assign req_take = take;
  assign rsp_done = (phase == PH_T4);

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_take,
  input logic [2:0] req_kind,
  input logic       bus_ready,
  input logic [2:0] bus_stat,
  input logic       bus_ale,
  input logic       bus_bhe_n,
  input logic       bus_rd_n,
  input logic       bus_inta_n,
  input logic       rsp_done
);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  assert_bhe_outside_t1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ale |-> bus_bhe_n);

  assert_passive_in_t3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> ##2 (bus_stat == 3'b111));

  assert_wait_holds_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !bus_ready) |=> !bus_rd_n);

  assert_no_strobe_in_t1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_inta_n));

  assert_ack_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_inta_n |-> !bus_rd_n);

  assert_never_take_passive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |-> (req_kind != 3'b111));

  assert_chain_to_t1_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && req_take) |=> bus_ale);

endmodule

bind mbus_seq mbus_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_take   (req_take),
  .req_kind   (req_kind),
  .bus_ready  (bus_ready),
  .bus_stat   (bus_stat),
  .bus_ale    (bus_ale),
  .bus_bhe_n  (bus_bhe_n),
  .bus_rd_n   (bus_rd_n),
  .bus_inta_n (bus_inta_n),
  .rsp_done   (rsp_done)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'b111;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic        req_bhe_n = 1'b1;
  logic [15:0] req_wdata = '0;
  logic        req_take;
  logic        bus_ready = 1'b1;
  logic [15:0] bus_ad_in = '0;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [3:0]  bus_a_hi;
  logic [2:0]  bus_stat;
  logic        bus_ale, bus_bhe_n, bus_rd_n, bus_den_n, bus_inta_n, rsp_done;
  logic [15:0] rsp_rdata;

  int total = 0;
  int bad = 0;

  // next request to present in T4 when chaining
  logic        nx_chain = 1'b0;
  logic [2:0]  nx_kind = '0;
  logic [19:0] nx_addr = '0;
  logic [1:0]  nx_seg = '0;
  logic        nx_bhe = 1'b1;
  logic [15:0] nx_wdata = '0;

  always #4 clk = ~clk;

  mbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_seg(req_seg), .req_bhe_n(req_bhe_n),
    .req_wdata(req_wdata), .req_take(req_take), .bus_ready(bus_ready),
    .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_a_hi(bus_a_hi), .bus_stat(bus_stat), .bus_ale(bus_ale),
    .bus_bhe_n(bus_bhe_n), .bus_rd_n(bus_rd_n), .bus_den_n(bus_den_n),
    .bus_inta_n(bus_inta_n), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_rest(input string req);
    chk(bus_stat == 3'b111, req, bus_stat, 3'b111);
    chk(!bus_ale && bus_rd_n && bus_den_n && bus_inta_n && bus_bhe_n && !bus_ad_oe && !rsp_done,
        req, {bus_ale, bus_rd_n, bus_den_n, bus_inta_n, bus_bhe_n, bus_ad_oe, rsp_done}, 7'b0111100);
  endtask

  task automatic do_cycle(input logic [2:0] k, input logic [19:0] a, input logic [1:0] s,
                          input logic b, input logic [15:0] wd, input int nw,
                          input logic [15:0] rv, input bit skip_acc);
    logic rd, wr;
    rd = (k == 3'b000) || (k == 3'b001) || (k == 3'b100) || (k == 3'b101);
    wr = (k == 3'b010) || (k == 3'b110);
    if (!skip_acc) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_seg = s; req_bhe_n = b; req_wdata = wd;
      #1;
      chk(req_take == 1'b1, "R2 take", req_take, 1);
      chk(bus_stat == k, "R4 stat at take", bus_stat, k);
    end
    // T1
    @(negedge clk);
    req_valid = 1'b0; bus_ready = 1'b0;
    #1;
    chk(bus_ale == 1'b1, "R3 ale", bus_ale, 1);
    chk(bus_ad_oe && bus_ad_out == a[15:0], "R3 low addr", bus_ad_out, a[15:0]);
    chk(bus_a_hi == a[19:16], "R3 high addr", bus_a_hi, a[19:16]);
    chk(bus_bhe_n == b, "R3 bhe", bus_bhe_n, b);
    chk(bus_stat == k, "R4 stat T1", bus_stat, k);
    // T2
    @(negedge clk);
    #1;
    chk(!bus_ale && bus_bhe_n, "R3 ale/bhe off T2", {bus_ale, bus_bhe_n}, 2'b01);
    chk(bus_stat == k, "R4 stat T2", bus_stat, k);
    chk(bus_a_hi == {2'b00, s}, "R5 seg T2", bus_a_hi, {2'b00, s});
    chk(bus_rd_n == !rd, "R7 rd T2", bus_rd_n, !rd);
    chk(bus_inta_n == (k != 3'b000), "R8 inta T2", bus_inta_n, k != 3'b000);
    chk(bus_den_n == (k == 3'b011), "R9 den T2", bus_den_n, k == 3'b011);
    if (wr) chk(bus_ad_oe && bus_ad_out == wd, "R10 wdata T2", bus_ad_out, wd);
    else    chk(!bus_ad_oe, "R10 no drive T2", bus_ad_oe, 0);
    // T3 and wait phases
    for (int i = 0; i <= nw; i++) begin
      @(negedge clk);
      bus_ready = (i == nw);
      bus_ad_in = (i == nw) ? rv : ~rv;
      #1;
      chk(bus_stat == 3'b111, "R4 passive T3/wait", bus_stat, 3'b111);
      chk(bus_rd_n == !rd, (i > 0) ? "R6 rd in wait" : "R7 rd T3", bus_rd_n, !rd);
      chk(bus_inta_n == (k != 3'b000), "R8 inta T3/wait", bus_inta_n, k != 3'b000);
      chk(bus_den_n == (k == 3'b011), "R9 den T3/wait", bus_den_n, k == 3'b011);
      chk(!rsp_done && !bus_ale, "R6 no early done", {rsp_done, bus_ale}, 0);
    end
    // T4
    @(negedge clk);
    bus_ready = 1'b1; bus_ad_in = 16'h0bad;
    if (nx_chain) begin
      req_valid = 1'b1; req_kind = nx_kind; req_addr = nx_addr; req_seg = nx_seg;
      req_bhe_n = nx_bhe; req_wdata = nx_wdata;
    end
    #1;
    chk(rsp_done == 1'b1, "R2 done T4", rsp_done, 1);
    chk(bus_rd_n && bus_inta_n, "R7 strobes off T4", {bus_rd_n, bus_inta_n}, 2'b11);
    chk(bus_den_n == !wr, "R9 den T4", bus_den_n, !wr);
    chk(bus_a_hi == {2'b00, s}, "R5 seg T4", bus_a_hi, {2'b00, s});
    if (wr) chk(bus_ad_oe && bus_ad_out == wd, "R10 wdata T4", bus_ad_out, wd);
    if (rd) chk(rsp_rdata == rv, "R11 rdata", rsp_rdata, rv);
    if (nx_chain) begin
      chk(req_take == 1'b1, "R13 take in T4", req_take, 1);
      chk(bus_stat == nx_kind, "R13 stat in T4", bus_stat, nx_kind);
    end else begin
      chk(bus_stat == 3'b111, "R4 passive T4", bus_stat, 3'b111);
      @(negedge clk);
      #1;
      chk_rest("R1 idle after cycle");
      chk(rsp_rdata == (rd ? rv : rsp_rdata), "R11 rdata held", rsp_rdata, rv);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk_rest("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk_rest("R1 after release");
  endtask

  task automatic t_read_fast();
    do_cycle(3'b101, 20'h4_4210, 2'b11, 1'b0, 16'h0, 0, 16'hA55A, 0);
  endtask

  task automatic t_read_waits();
    do_cycle(3'b001, 20'h0_03F8, 2'b11, 1'b1, 16'h0, 2, 16'h1234, 0);
  endtask

  task automatic t_io_write();
    do_cycle(3'b010, 20'h0_0060, 2'b00, 1'b0, 16'hBEEF, 1, 16'h0, 0);
  endtask

  task automatic t_ack();
    do_cycle(3'b000, 20'h0_0000, 2'b00, 1'b0, 16'h0, 1, 16'h0008, 0);
  endtask

  task automatic t_halt();
    do_cycle(3'b011, 20'h0_0002, 2'b10, 1'b1, 16'h0, 0, 16'h0, 0);
  endtask

  task automatic t_passive_ignored();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'b111; req_addr = 20'hF_FFF0;
      #1;
      chk(req_take == 1'b0, "R12 passive not taken", req_take, 0);
      chk(!bus_ale, "R12 no cycle", bus_ale, 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk_rest("R12 bus idle");
  endtask

  task automatic t_back_to_back();
    nx_chain = 1'b1; nx_kind = 3'b110; nx_addr = 20'hA_BCDE; nx_seg = 2'b01;
    nx_bhe = 1'b1; nx_wdata = 16'hC0DE;
    do_cycle(3'b100, 20'h1_2345, 2'b10, 1'b0, 16'h0, 0, 16'h9090, 0);
    nx_chain = 1'b0;
    do_cycle(3'b110, 20'hA_BCDE, 2'b01, 1'b1, 16'hC0DE, 0, 16'h0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_read_fast();
    t_read_waits();
    t_io_write();
    t_ack();
    t_halt();
    t_passive_ignored();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule